// File: doc/BRIEF.md
# Asynchronous Coefficient Write Capture

This block sits between a slow write port, which runs with no fixed relation to the core clock, and the coefficient storage of a filter. The write side presents a 32-bit word holding two 16-bit coefficients and raises a write strobe. The strobe goes through a synchronizer chain into the core clock domain. A small qualifier state machine counts the core clocks during which the synchronized strobe has stayed high. On the third such clock it samples the data bus and issues one push into a synchronous FIFO. The data bus is treated as stable at that point.

Each strobe pulse gives exactly one push, however long it stays high. The qualifier only re-arms once it has seen the strobe low again. A pulse that drops before the capture count is reached writes nothing and sets a sticky short-pulse flag. A capture that finds the FIFO full is dropped and sets a sticky overflow flag. Both flags clear only on reset. The write side is expected to keep the strobe high for at least six core clocks and low for at least six core clocks between writes. The consumer drains the FIFO through a read enable and sees the data one clock later. The FIFO reports full, empty and its fill count.

Top module: `coef_write_capture`

## Requirements
- R1: After reset, `fifo_empty` is 1, `fifo_full` is 0, `fifo_count` is 0, and `short_err` and `ovf_err` are 0.
- R2: A strobe held high for 3 or more consecutive core clock samples pushes exactly one word into the FIFO.
- R3: A strobe held high for only 1 or 2 core clock samples pushes nothing and sets `short_err`.
- R4: The word pushed is the value on `wr_data` while the strobe is high. Words leave the FIFO in the order they were captured. `rd_data` carries the oldest word on the clock after an accepted `rd_en`.
- R5: A capture that occurs while `fifo_full` is 1 is discarded and sets `ovf_err`. The stored words and `fifo_count` do not change.
- R6: `fifo_count` equals the number of stored words. `fifo_full` is 1 exactly when the count equals FIFO_DEPTH, and `fifo_empty` is 1 exactly when the count is 0.
- R7: `rd_en` while `fifo_empty` is 1 has no effect: the count stays 0 and `rd_data` keeps its previous value.
- R8: After a capture, no further push occurs until the synchronized strobe has been low for at least one clock. A long pulse therefore still yields one word.
- R9: `short_err` and `ovf_err` stay at 1 once set, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_strobe | input | 1 | Write strobe, asynchronous to clk |
| wr_data | input | DATA_W (32) | Coefficient word, two 16-bit coefficients |
| rd_en | input | 1 | Pop one word from the FIFO |
| rd_data | output | DATA_W (32) | Popped word, valid one clock after rd_en |
| fifo_full | output | 1 | FIFO holds FIFO_DEPTH words |
| fifo_empty | output | 1 | FIFO holds no words |
| fifo_count | output | $clog2(FIFO_DEPTH+1) | Number of stored words |
| short_err | output | 1 | Sticky: a strobe pulse was too short to capture |
| ovf_err | output | 1 | Sticky: a capture was dropped because the FIFO was full |

## Verification
The strobe is swept through every high length from one to eight core clocks, each time from a fresh reset. Lengths one and two must only raise the short-pulse flag. Three is the first length that captures, which exposes an off-by-one in the capture count. Lengths up to eight must still give one word each, which separates a single push per pulse from a re-triggering qualifier. A fill run pushes one more word than the FIFO depth, then drains and reads once more while empty. This shows whether the full flag, the drop on overflow, the word order and the empty-read guard each behave as required. A final short-then-long pair shows that the short-pulse flag stays set while a valid write still goes through.

// File: rtl/coefcap_pkg.sv
package coefcap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_HOLD  = 2'd2
  } cap_state_t;
endpackage

// File: rtl/coefcap_sync.sv
module coefcap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= async_in;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], async_in};
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/coefcap_qualify.sv
module coefcap_qualify
  import coefcap_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int CAPTURE_CLKS = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  logic [DATA_W-1:0] data_in,
  output logic              push,
  output logic [DATA_W-1:0] push_data,
  output logic              short_pulse
);
  localparam int CNT_W = $clog2(CAPTURE_CLKS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CAPTURE_CLKS - 1);

  cap_state_t       state;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      cnt         <= '0;
      push        <= 1'b0;
      push_data   <= '0;
      short_pulse <= 1'b0;
    end else begin
      push        <= 1'b0;
      short_pulse <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (strobe) begin
            if (CAPTURE_CLKS <= 1) begin
              push      <= 1'b1;
              push_data <= data_in;
              state     <= ST_HOLD;
            end else begin
              cnt   <= CNT_W'(1);
              state <= ST_COUNT;
            end
          end
        end
        ST_COUNT: begin
          if (!strobe) begin
            short_pulse <= 1'b1;
            cnt         <= '0;
            state       <= ST_IDLE;
          end else if (cnt == LAST) begin
            push      <= 1'b1;
            push_data <= data_in;
            cnt       <= '0;
            state     <= ST_HOLD;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_HOLD: begin
          if (!strobe) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/coefcap_fifo.sv
module coefcap_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic                       rd_en,
  output logic [DATA_W-1:0]          rd_data,
  output logic                       full,
  output logic                       empty,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       wr_drop
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     count_next;
  logic              wr_ok, rd_ok;

  assign wr_ok   = wr_en && !full;
  assign rd_ok   = rd_en && !empty;
  assign wr_drop = wr_en && full;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST_PTR) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    case ({wr_ok, rd_ok})
      2'b10:   count_next = count + CW'(1);
      2'b01:   count_next = count - CW'(1);
      default: count_next = count;
    endcase
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_ok) rd_data <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      full   <= 1'b0;
      empty  <= 1'b1;
    end else begin
      if (wr_ok) wr_ptr <= bump(wr_ptr);
      if (rd_ok) rd_ptr <= bump(rd_ptr);
      count <= count_next;
      full  <= (count_next == FULL_CNT);
      empty <= (count_next == '0);
    end
  end
endmodule

// File: rtl/coef_write_capture.sv
module coef_write_capture #(
  parameter int DATA_W       = 32,
  parameter int FIFO_DEPTH   = 16,
  parameter int CAPTURE_CLKS = 3,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            wr_strobe,
  input  logic [DATA_W-1:0]               wr_data,
  input  logic                            rd_en,
  output logic [DATA_W-1:0]               rd_data,
  output logic                            fifo_full,
  output logic                            fifo_empty,
  output logic [$clog2(FIFO_DEPTH+1)-1:0] fifo_count,
  output logic                            short_err,
  output logic                            ovf_err
);
  logic              strobe_s;
  logic              cap_push;
  logic [DATA_W-1:0] cap_data;
  logic              cap_short;
  logic              fifo_drop;

  coefcap_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (wr_strobe),
    .sync_out (strobe_s)
  );

  coefcap_qualify #(.DATA_W(DATA_W), .CAPTURE_CLKS(CAPTURE_CLKS)) u_qual (
    .clk         (clk),
    .rst         (rst),
    .strobe      (strobe_s),
    .data_in     (wr_data),
    .push        (cap_push),
    .push_data   (cap_data),
    .short_pulse (cap_short)
  );

  coefcap_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cap_push),
    .wr_data (cap_data),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .full    (fifo_full),
    .empty   (fifo_empty),
    .count   (fifo_count),
    .wr_drop (fifo_drop)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      short_err <= 1'b0;
      ovf_err   <= 1'b0;
    end else begin
      if (cap_short) short_err <= 1'b1;
      if (fifo_drop) ovf_err   <= 1'b1;
    end
  end
endmodule

// File: rtl/coef_write_capture_chk.sv
module coef_write_capture_chk #(
  parameter int FIFO_DEPTH = 16
) (
  input logic                            clk,
  input logic                            rst,
  input logic                            sync_strobe,
  input logic                            push,
  input logic                            rd_en,
  input logic                            fifo_full,
  input logic                            fifo_empty,
  input logic [$clog2(FIFO_DEPTH+1)-1:0] fifo_count,
  input logic                            short_err,
  input logic                            ovf_err
);
  localparam int CW = $clog2(FIFO_DEPTH + 1);

  // R2: a push needs three consecutive high samples of the synchronized strobe
  assert_push_qualified_R2: assert property (@(posedge clk) disable iff (rst)
    push |-> ($past(sync_strobe, 1) && $past(sync_strobe, 2) && $past(sync_strobe, 3)));

  // R8: pushes never come back to back; the strobe must be seen low first
  assert_single_push_R8: assert property (@(posedge clk) disable iff (rst)
    push |=> !push);

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    (push && fifo_full) |=> ovf_err);

  assert_full_held_R5: assert property (@(posedge clk) disable iff (rst)
    (push && fifo_full && !rd_en) |=> fifo_full);

  assert_count_bound_R6: assert property (@(posedge clk) disable iff (rst)
    fifo_count <= CW'(FIFO_DEPTH));

  assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
    !(fifo_full && fifo_empty));

  assert_empty_read_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && fifo_empty && !push) |=> (fifo_count == '0));

  assert_sticky_short_R9: assert property (@(posedge clk) disable iff (rst)
    short_err |=> short_err);

  assert_sticky_ovf_R9: assert property (@(posedge clk) disable iff (rst)
    ovf_err |=> ovf_err);
endmodule

bind coef_write_capture coef_write_capture_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .sync_strobe (strobe_s),
  .push        (cap_push),
  .rd_en       (rd_en),
  .fifo_full   (fifo_full),
  .fifo_empty  (fifo_empty),
  .fifo_count  (fifo_count),
  .short_err   (short_err),
  .ovf_err     (ovf_err)
);

// File: tb/sim_coef_write_capture.sv
`timescale 1ns/1ps
module sim_coef_write_capture;
  localparam int DEPTH = 4;
  localparam int CW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_strobe = 1'b0;
  logic [31:0]   wr_data = '0;
  logic          rd_en = 1'b0;
  logic [31:0]   rd_data;
  logic          fifo_full, fifo_empty, short_err, ovf_err;
  logic [CW-1:0] fifo_count;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  coef_write_capture #(.DATA_W(32), .FIFO_DEPTH(DEPTH), .CAPTURE_CLKS(3), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .wr_strobe(wr_strobe), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
    .fifo_count(fifo_count), .short_err(short_err), .ovf_err(ovf_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_strobe = 1'b0; rd_en = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse(input int n, input logic [31:0] d);
    @(negedge clk);
    wr_data = d; wr_strobe = 1'b1;
    repeat (n) @(negedge clk);
    wr_strobe = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic rd_word(output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  function automatic logic [31:0] pat(input int k);
    return 32'hA500_3C00 ^ (32'(k) * 32'h0101_0111);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] got;
    do_reset();
    // R1 reset state
    chk(fifo_empty == 1'b1, "R1", "empty", 32'(fifo_empty), 32'd1);
    chk(fifo_full == 1'b0, "R1", "full", 32'(fifo_full), 32'd0);
    chk(fifo_count == '0, "R1", "count", 32'(fifo_count), 32'd0);
    chk(short_err == 1'b0, "R1", "short_err", 32'(short_err), 32'd0);
    chk(ovf_err == 1'b0, "R1", "ovf_err", 32'(ovf_err), 32'd0);

    // R3: too-short pulses, lengths 1 and 2
    for (int n = 1; n <= 2; n++) begin
      do_reset();
      pulse(n, pat(n));
      chk(fifo_count == '0, "R3", "count after short pulse", 32'(fifo_count), 32'd0);
      chk(short_err == 1'b1, "R3", "short_err after short pulse", 32'(short_err), 32'd1);
      repeat (10) @(negedge clk);
      chk(short_err == 1'b1, "R9", "short_err held", 32'(short_err), 32'd1);
    end

    // R2 / R8 / R4: lengths 3..8 give exactly one word holding the bus value
    for (int n = 3; n <= 8; n++) begin
      do_reset();
      pulse(n, pat(n));
      chk(fifo_count == CW'(1), "R2", "one word per pulse", 32'(fifo_count), 32'd1);
      chk(short_err == 1'b0, "R2", "no short_err", 32'(short_err), 32'd0);
      if (n >= 6)
        chk(fifo_count == CW'(1), "R8", "long pulse single push", 32'(fifo_count), 32'd1);
      rd_word(got);
      chk(got == pat(n), "R4", "captured data", got, pat(n));
      chk(fifo_empty == 1'b1, "R6", "empty after drain", 32'(fifo_empty), 32'd1);
    end

    // R5 / R6 / R4 / R7 / R9: fill, overflow, drain, empty read
    do_reset();
    for (int k = 0; k < DEPTH; k++) begin
      pulse(6, pat(20 + k));
      chk(fifo_count == CW'(k + 1), "R6", "fill count", 32'(fifo_count), 32'(k + 1));
    end
    chk(fifo_full == 1'b1, "R6", "full at depth", 32'(fifo_full), 32'd1);
    chk(ovf_err == 1'b0, "R5", "no ovf before extra push", 32'(ovf_err), 32'd0);
    pulse(6, 32'hDEAD_BEEF);
    chk(ovf_err == 1'b1, "R5", "ovf_err on push when full", 32'(ovf_err), 32'd1);
    chk(fifo_count == CW'(DEPTH), "R5", "count unchanged on drop", 32'(fifo_count), 32'(DEPTH));
    for (int k = 0; k < DEPTH; k++) begin
      rd_word(got);
      chk(got == pat(20 + k), "R4", "fifo order", got, pat(20 + k));
      chk(got != 32'hDEAD_BEEF, "R5", "dropped word absent", got, pat(20 + k));
    end
    chk(fifo_empty == 1'b1, "R6", "empty after drain", 32'(fifo_empty), 32'd1);
    chk(fifo_full == 1'b0, "R6", "not full after drain", 32'(fifo_full), 32'd0);
    rd_word(got);
    chk(fifo_count == '0, "R7", "count after empty read", 32'(fifo_count), 32'd0);
    chk(got == pat(20 + DEPTH - 1), "R7", "rd_data kept on empty read", got, pat(20 + DEPTH - 1));
    chk(ovf_err == 1'b1, "R9", "ovf_err held", 32'(ovf_err), 32'd1);

    // R3 / R2 / R9: short pulse then valid pulse
    do_reset();
    pulse(2, 32'h1111_2222);
    pulse(7, 32'h3333_4444);
    chk(short_err == 1'b1, "R9", "short_err survives valid write", 32'(short_err), 32'd1);
    chk(fifo_count == CW'(1), "R2", "only valid pulse stored", 32'(fifo_count), 32'd1);
    rd_word(got);
    chk(got == 32'h3333_4444, "R4", "valid word after short", got, 32'h3333_4444);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule